// File: doc/BRIEF.md
# Five-Pin Bidirectional GPIO Port

This block controls a small bank of general-purpose pins from a synchronous register bus. Each pin has three stored bits: an output latch, a direction bit and a pull-up enable. A direction bit of 1 drives the pin from its latch and asserts its output enable. A direction bit of 0 leaves the pin as an input. A pin's pull-up request is raised only while that pin is an input and its enable bit is set. Setting the pin to output clears the request without touching the stored enable bit.

Software reads the data offset to get a per-bit blend. Output pins return their latch bit. Input pins return the synchronized pin level. The latch can be written at any time, so the intended output value can be loaded before a pin is switched to output, and the pin then starts driving that value without a glitch. Read data is registered, and unmapped offsets are inert.

Top module: `gpio_port`

## Requirements
- R1: After reset, the data latch, the direction bits and the pull-up enables are all 0, `pin_oe` and `pin_pu` are all 0, and `bus_rdata` is 0.
- R2: The direction register at offset 0x04 and the pull-up enable register at offset 0x08 read back their written values in bits 4..0. Bits above bit 4 read as 0 in every register.
- R3: `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals latch bit i, from the cycle after the write.
- R4: For a read of offset 0x00, bit i of the result is latch bit i when direction bit i is 1, and the synchronized level of `pin_in[i]` when direction bit i is 0.
- R5: A write to offset 0x00 updates all latch bits whatever the direction bits are. The readback of an input pin does not change after such a write.
- R6: `pin_pu[i]` is 1 only when pull-up enable bit i is 1 and direction bit i is 0. Writing the direction register leaves the stored pull-up enables unchanged.
- R7: `pin_in` passes through a two-flop synchronizer. A pin change made half a cycle before edge k is returned only by reads strobed at edge k+2 or later. Reads strobed at edges k and k+1 return the old level.
- R8: `bus_rdata` is registered. It carries the addressed value in the cycle after the edge that sampled `bus_rd`, and 0 after any edge where `bus_rd` was low.
- R9: A read of an offset other than 0x00, 0x04 or 0x08 returns 0. A write to such an offset changes no register.
- R10: If the latch is written before the direction bit goes to 1, `pin_out` already holds the new value in the first cycle in which `pin_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 5 | Raw pin levels |
| pin_out | output | 5 | Per-pin output value |
| pin_oe | output | 5 | Per-pin output enable |
| pin_pu | output | 5 | Per-pin pull-up request |

## Verification
The bench builds the block with its default parameters: five pins, 8-bit address and data, and a two-stage synchronizer. With eight data bits and five pins, three upper bits exist in every register, so the bench can check that those bits read as zero. With two synchronizer stages, the bench can check the latency edge by edge, including the two reads that still return the old pin level. The data-read patterns mix output and input bits in different proportions, so both sources of the per-bit blend are exercised in a single read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PUE  = 2'd3
  } reg_sel_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end

    // R7
    sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> stage_q[s] == $past(stage_q[s-1]));
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int NUM_PINS = 5,
  parameter int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  gpio_pkg::reg_sel_t   wr_sel,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [NUM_PINS-1:0]  latch_q,
  output logic [NUM_PINS-1:0]  dir_q,
  output logic [NUM_PINS-1:0]  pue_q
);
  import gpio_pkg::*;

  logic [NUM_PINS-1:0] wval;
  assign wval = bus_wdata[NUM_PINS-1:0];

  if (DATA_W > NUM_PINS) begin : g_hi
    logic wdata_hi_unused;
    assign wdata_hi_unused = ^bus_wdata[DATA_W-1:NUM_PINS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      pue_q   <= '0;
    end else if (bus_wr) begin
      case (wr_sel)
        SEL_DATA: latch_q <= wval;
        SEL_DIR:  dir_q   <= wval;
        SEL_PUE:  pue_q   <= wval;
        default:  ;
      endcase
    end
  end

  // R1
  regs_reset_chk: assert property (@(posedge clk)
    rst |=> (latch_q == '0 && dir_q == '0 && pue_q == '0));

  // R5
  latch_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && wr_sel == SEL_DATA) |=> latch_q == $past(wval));

  // R6
  pue_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && wr_sel == SEL_DIR) |=> $stable(pue_q));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && wr_sel == SEL_NONE) |=> ($stable(latch_q) && $stable(dir_q) && $stable(pue_q)));

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
  parameter int NUM_PINS = 5,
  parameter int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  gpio_pkg::reg_sel_t   rd_sel,
  input  logic                 bus_rd,
  input  logic [NUM_PINS-1:0]  latch_q,
  input  logic [NUM_PINS-1:0]  dir_q,
  input  logic [NUM_PINS-1:0]  pue_q,
  input  logic [NUM_PINS-1:0]  pin_sync,
  output logic [DATA_W-1:0]    bus_rdata
);
  import gpio_pkg::*;

  logic [NUM_PINS-1:0] data_view;
  logic [NUM_PINS-1:0] pick;
  logic [DATA_W-1:0]   rdata_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_view
    assign data_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
  end

  always_comb begin
    case (rd_sel)
      SEL_DATA: pick = data_view;
      SEL_DIR:  pick = dir_q;
      SEL_PUE:  pick = pue_q;
      default:  pick = '0;
    endcase
    rdata_d = '0;
    if (bus_rd) rdata_d[NUM_PINS-1:0] = pick;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rdata_d;
  end

  // R8
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && rd_sel == SEL_NONE) |=> bus_rdata == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NUM_PINS    = 5,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_DATA    = 'h00,
  parameter int OFS_DIR     = 'h04,
  parameter int OFS_PUE     = 'h08
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pu
);
  import gpio_pkg::*;

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_PUE  = ADDR_W'(OFS_PUE);

  reg_sel_t            sel;
  logic [NUM_PINS-1:0] latch_q, dir_q, pue_q, pin_sync;

  always_comb begin
    if      (bus_addr == A_DATA) sel = SEL_DATA;
    else if (bus_addr == A_DIR)  sel = SEL_DIR;
    else if (bus_addr == A_PUE)  sel = SEL_PUE;
    else                         sel = SEL_NONE;
  end

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_sel(sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q)
  );

  gpio_rdmux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd_sel(sel), .bus_rd(bus_rd),
    .latch_q(latch_q), .dir_q(dir_q), .pue_q(pue_q), .pin_sync(pin_sync),
    .bus_rdata(bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
  assign pin_pu  = pue_q & ~dir_q;

  // R6
  pu_off_when_out_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);

  // R10
  oe_rise_after_dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~$past(pin_oe)) != '0 |-> $past(bus_wr && bus_addr == A_DIR));

endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [4:0] pin_in = '0;
  logic [4:0] pin_out, pin_oe, pin_pu;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [7:0] blend(input logic [4:0] l, input logic [4:0] d, input logic [4:0] p);
    return {3'b000, (l & d) | (p & ~d)};
  endfunction

  task automatic settle_pins(input logic [4:0] p);
    @(negedge clk); pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    check("R1", "oe", {3'b0, pin_oe}, 8'h00);
    check("R1", "pu", {3'b0, pin_pu}, 8'h00);
    check("R1", "out", {3'b0, pin_out}, 8'h00);
    check("R1", "rdata", bus_rdata, 8'h00);
    rd(8'h04, v); check("R1", "dir", v, 8'h00);
    rd(8'h08, v); check("R1", "pue", v, 8'h00);
  endtask

  task automatic test_regs_rw();
    logic [7:0] v;
    wr(8'h04, 8'hFF); rd(8'h04, v); check("R2", "dir upper bits", v, 8'h1F);
    wr(8'h04, 8'h0A); rd(8'h04, v); check("R2", "dir readback", v, 8'h0A);
    check("R3", "oe follows dir", {3'b0, pin_oe}, 8'h0A);
    wr(8'h08, 8'hE5); rd(8'h08, v); check("R2", "pue readback", v, 8'h05);
    wr(8'h00, 8'hF3); check("R3", "out follows latch", {3'b0, pin_out}, 8'h13);
    wr(8'h04, 8'h00); wr(8'h08, 8'h00);
  endtask

  task automatic test_data_mux();
    logic [7:0] v;
    settle_pins(5'b01010);
    wr(8'h00, 8'h06);
    wr(8'h04, 8'h11); rd(8'h00, v); check("R4", "mix A", v, blend(5'h06, 5'h11, 5'h0A));
    wr(8'h04, 8'h1E); rd(8'h00, v); check("R4", "mix B", v, blend(5'h06, 5'h1E, 5'h0A));
    wr(8'h04, 8'h00); rd(8'h00, v); check("R4", "all input", v, 8'h0A);
    wr(8'h04, 8'h1F); rd(8'h00, v); check("R4", "all output", v, 8'h06);
    wr(8'h04, 8'h00);
  endtask

  task automatic test_latch_in_input();
    logic [7:0] v;
    settle_pins(5'b10101);
    wr(8'h04, 8'h03);
    wr(8'h00, 8'h1F); rd(8'h00, v);
    check("R5", "input bits keep pin level", v, blend(5'h1F, 5'h03, 5'h15));
    check("R5", "latch fully written", {3'b0, pin_out}, 8'h1F);
    wr(8'h04, 8'h1F); rd(8'h00, v); check("R5", "latch seen when output", v, 8'h1F);
    wr(8'h04, 8'h00);
  endtask

  task automatic test_pullup();
    logic [7:0] v;
    wr(8'h08, 8'h1B); check("R6", "pu inputs", {3'b0, pin_pu}, 8'h1B);
    wr(8'h04, 8'h09); check("R6", "pu gated by dir", {3'b0, pin_pu}, 8'h12);
    rd(8'h08, v); check("R6", "pue kept", v, 8'h1B);
    wr(8'h04, 8'h00); check("R6", "pu restored", {3'b0, pin_pu}, 8'h1B);
    wr(8'h08, 8'h00);
  endtask

  task automatic test_sync_delay();
    settle_pins(5'b00000);
    @(negedge clk); pin_in = 5'b11001; bus_addr = 8'h00; bus_rd = 1'b1;
    @(negedge clk); check("R7", "read at edge k", bus_rdata, 8'h00);
    @(negedge clk); check("R7", "read at edge k+1", bus_rdata, 8'h00);
    @(negedge clk); check("R7", "read at edge k+2", bus_rdata, 8'h19);
    bus_rd = 1'b0;
  endtask

  task automatic test_read_timing();
    logic [7:0] v;
    wr(8'h08, 8'h07);
    rd(8'h08, v); check("R8", "valid after strobe", v, 8'h07);
    @(negedge clk); check("R8", "zero without strobe", bus_rdata, 8'h00);
    wr(8'h08, 8'h00);
  endtask

  task automatic test_unmapped();
    logic [7:0] v;
    wr(8'h00, 8'h0C); wr(8'h04, 8'h05); wr(8'h08, 8'h12);
    wr(8'h0C, 8'h1F); wr(8'h01, 8'h1F); wr(8'h84, 8'h1F);
    rd(8'h0C, v); check("R9", "unmapped read", v, 8'h00);
    rd(8'h04, v); check("R9", "dir untouched", v, 8'h05);
    rd(8'h08, v); check("R9", "pue untouched", v, 8'h12);
    check("R9", "latch untouched", {3'b0, pin_out}, 8'h0C);
    wr(8'h04, 8'h00); wr(8'h08, 8'h00);
  endtask

  task automatic test_glitch_free();
    wr(8'h00, 8'h15);
    check("R10", "oe low before enable", {3'b0, pin_oe}, 8'h00);
    @(negedge clk); bus_addr = 8'h04; bus_wdata = 8'h1F; bus_wr = 1'b1;
    #1 check("R10", "oe still low before edge", {3'b0, pin_oe}, 8'h00);
    @(negedge clk); bus_wr = 1'b0;
    check("R10", "oe high", {3'b0, pin_oe}, 8'h1F);
    check("R10", "out already new", {3'b0, pin_out}, 8'h15);
    wr(8'h04, 8'h00);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_regs_rw();
    test_data_mux();
    test_latch_in_input();
    test_pullup();
    test_sync_delay();
    test_read_timing();
    test_unmapped();
    test_glitch_free();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule